// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets logic running on a single clock read and write an external asynchronous static RAM of 512K bytes. The memory has three active-low strobes (chip select, write enable, output enable) and one shared data bus that both sides can drive. The user side issues one request at a time: a read/write flag, a 19-bit address and a write byte. The controller returns a single-cycle completion pulse, and a read byte when the access was a read. The memory side presents the address, the three strobes, the byte to be written and an enable for the tri-state data driver.

All analog minimums are turned into whole clock cycles at elaboration time from the clock period parameter. These minimums are the access time, the write pulse, the data setup before the end of a write, and the time the memory needs to float its outputs. Output enable stays high for the whole of every write, which allows the shorter write pulse. The bus is handed over between the two drivers only through released cycles.

States: `ST_IDLE` (all strobes high, request taken here), `ST_RD_ACCESS` (chip select and output enable low for the access count), `ST_RD_END` (strobes high, bus released, completion pulse), `ST_RD_TURN` (extra released cycles when the float time needs more than one), `ST_WR_PULSE` (chip select and write enable low, data driven), `ST_WR_END` (strobes high, data still driven for hold, completion pulse). Transitions: IDLE→RD_ACCESS or IDLE→WR_PULSE on a request; RD_ACCESS→RD_END when the access count expires; RD_END→RD_TURN when the release count exceeds one, otherwise RD_END→IDLE; RD_TURN→IDLE when its count expires; WR_PULSE→WR_END when the pulse count expires; WR_END→IDLE always.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write enable and output enable are high (1), the data driver enable is 0 and done is 0.
- R2: The strobes only take three combinations: read (cs_n=0, we_n=1, oe_n=0), write (cs_n=0, we_n=0, oe_n=1) and idle (cs_n=1, we_n=1, oe_n=1).
- R3: A read keeps chip select and output enable low for exactly RD_CYC = ceil(T_ACCESS_NS / CLK_PERIOD_NS) cycles. The bus is sampled at the clock edge that ends them, and the byte appears on rdata_o together with done in the next cycle.
- R4: A write keeps write enable low for exactly WP_CYC = ceil(max(T_WPULSE_NS, T_DSETUP_NS) / CLK_PERIOD_NS) cycles with the request's byte on the bus. A later read of that address returns the byte.
- R5: Output enable is high during every cycle in which write enable is low.
- R6: The memory address does not change while chip select stays low.
- R7: The data driver is enabled only in cycles where write enable is low or was low in the previous cycle, and never while the memory is selected for reading.
- R8: Before the controller drives the bus after a read, at least TA_CYC = ceil(T_RELEASE_NS / CLK_PERIOD_NS) cycles pass with neither side driving. Output enable never falls in the cycle right after the driver was enabled.
- R9: A request is taken only in the idle state. Changes to the address, flag or data while an access is under way have no effect on that access.
- R10: Every request produces exactly one done pulse, one cycle wide. With the request raised in idle, done comes RD_CYC+1 cycles after a read is raised and WP_CYC+1 cycles after a write is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request; held until done |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write byte |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with done after a read |
| mem_addr_o | output | 19 | Memory address |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe_o | output | 1 | Tri-state driver enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte returned by the memory |

## Verification
The bench drives writes and reads with patterns 00, FF, 55 and AA at the lowest and highest addresses and in between. This separates a correct data path from stuck, swapped or misaligned bits and from wrong address capture. Alternating write-read-write-read requests to a single address, issued with no idle gap, show whether the turnaround cycles and the driver window are kept when direction changes. The same sequence also shows whether stale or junk bus values are captured instead of the memory's byte. A read whose address and flag are changed mid-access, followed by a read of that second address, shows whether inputs are ignored while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_END,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_END
    } ctrl_state_e;

    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= value_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept_i) begin
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end
            if (capture_i)
                rdata_q <= bus_i;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACCESS_NS   = 20,
    parameter int T_WPULSE_NS   = 14,
    parameter int T_DSETUP_NS   = 9,
    parameter int T_RELEASE_NS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC  = max2(1, ceil_div(T_ACCESS_NS, CLK_PERIOD_NS));
    localparam int WP_CYC  = max2(1, ceil_div(max2(T_WPULSE_NS, T_DSETUP_NS), CLK_PERIOD_NS));
    localparam int TA_CYC  = max2(1, ceil_div(T_RELEASE_NS, CLK_PERIOD_NS));
    localparam int CNT_MAX = max2(RD_CYC, max2(WP_CYC, TA_CYC));
    localparam int CNT_W   = max2(1, $clog2(CNT_MAX + 1));

    localparam logic [CNT_W-1:0] LD_RD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WP = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TA = CNT_W'(max2(TA_CYC - 2, 0));

    ctrl_state_e      state_q, state_d;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_value;
    logic             accept, capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and timer control
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_value = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_value = wr_i ? LD_WP : LD_RD;
                    state_d   = wr_i ? ST_WR_PULSE : ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_zero) begin
                    capture = 1'b1;
                    state_d = ST_RD_END;
                end
            end
            ST_RD_END: begin
                if (TA_CYC > 1) begin
                    tmr_load  = 1'b1;
                    tmr_value = LD_TA;
                    state_d   = ST_RD_TURN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_TURN:  if (tmr_zero) state_d = ST_IDLE;
            ST_WR_PULSE: if (tmr_zero) state_d = ST_WR_END;
            ST_WR_END:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // strobe and driver outputs
    always_comb begin
        mem_cs_n_o  = 1'b1;
        mem_we_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RD_TURN: ;
            ST_RD_ACCESS: begin
                mem_cs_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
            end
            ST_RD_END: done_o = 1'b1;
            ST_WR_PULSE: begin
                mem_cs_n_o  = 1'b0;
                mem_we_n_o  = 1'b0;
                mem_dq_oe_o = 1'b1;
            end
            ST_WR_END: begin
                mem_dq_oe_o = 1'b1;
                done_o      = 1'b1;
            end
            default: ;
        endcase
    end

    sram_cyc_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_value),
        .zero_o  (tmr_zero)
    );

    sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .capture_i (capture),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .bus_i     (mem_dq_i),
        .addr_q    (mem_addr_o),
        .wdata_q   (mem_dq_o),
        .rdata_q   (rdata_o)
    );

    // R5: output enable stays high through the write strobe
    a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (mem_oe_n_o && !mem_cs_n_o));

    // R6: address held while selected
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

    // R7: driver only in the write window
    a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> (!mem_we_n_o || $past(!mem_we_n_o)));

    // R8: output enable never falls straight after the driver was on
    a_r8_no_oe_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));

    // R8: driver never rises straight after the memory drove
    a_r8_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> $past(mem_oe_n_o));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: strobes only leave idle after a request
    a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n_o) |-> $past(req_i));
endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
    localparam int CLK_NS = 4;
    localparam int EXP_RD = (20 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WP = (14 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_TA = (5 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, wr_i = 1'b0;
    logic [18:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        done_o;
    logic [7:0]  rdata_o;
    logic [18:0] mem_addr_o;
    logic        mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .rdata_o(rdata_o),
        .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o),
        .mem_oe_n_o(mem_oe_n_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
        .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural memory and reference contents
    logic [7:0] mem_arr [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ref_byte(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    // monitor state
    int we_lo = 0, oe_lo = 0, since_mem = 100, since_ctl = 100;
    logic prev_cs_n = 1'b1, prev_we_n = 1'b1, prev_done = 1'b0, prev_dq_oe = 1'b0;
    logic [18:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R2 legal strobe combinations
            check((mem_cs_n_o && mem_we_n_o && mem_oe_n_o) ||
                  (!mem_cs_n_o && mem_we_n_o && !mem_oe_n_o) ||
                  (!mem_cs_n_o && !mem_we_n_o && mem_oe_n_o),
                  "R2 strobe combination", {mem_cs_n_o, mem_we_n_o, mem_oe_n_o}, 0);
            // R5
            if (!mem_we_n_o)
                check(mem_oe_n_o, "R5 oe during write", mem_oe_n_o, 1);
            // R6
            if (!mem_cs_n_o && !prev_cs_n)
                check(mem_addr_o == prev_addr, "R6 address stable", mem_addr_o, prev_addr);
            // R7
            if (mem_dq_oe_o)
                check(!mem_we_n_o || !prev_we_n, "R7 driver window", mem_we_n_o, 0);
            if (!mem_cs_n_o && !mem_oe_n_o)
                check(!mem_dq_oe_o, "R7 contention", mem_dq_oe_o, 0);
            // R8
            if (mem_dq_oe_o && !prev_dq_oe)
                check(since_mem >= EXP_TA, "R8 gap after read", since_mem, EXP_TA);
            if (!mem_oe_n_o && !mem_cs_n_o && since_ctl < 100)
                check(since_ctl >= 1, "R8 gap after write", since_ctl, 1);
            // R3 / R4 strobe lengths
            if (!mem_we_n_o) we_lo++;
            else if (we_lo != 0) begin
                check(we_lo == EXP_WP, "R4 write pulse length", we_lo, EXP_WP);
                we_lo = 0;
            end
            if (!mem_oe_n_o) oe_lo++;
            else if (oe_lo != 0) begin
                check(oe_lo == EXP_RD, "R3 read strobe length", oe_lo, EXP_RD);
                oe_lo = 0;
            end
            // R10
            if (done_o)
                check(!prev_done, "R10 single done pulse", prev_done, 0);
            // memory model
            if (!mem_cs_n_o && !mem_we_n_o) mem_arr[int'(mem_addr_o)] = mem_dq_o;
            if (!mem_cs_n_o && mem_we_n_o && !mem_oe_n_o)
                mem_dq_i <= mem_arr.exists(int'(mem_addr_o)) ? mem_arr[int'(mem_addr_o)] : 8'h00;
            else
                mem_dq_i <= 8'hEE;
            since_mem = (!mem_cs_n_o && !mem_oe_n_o) ? 0 : since_mem + 1;
            since_ctl = mem_dq_oe_o ? 0 : ((since_ctl < 100) ? since_ctl + 1 : since_ctl);
        end
        prev_cs_n  = mem_cs_n_o;
        prev_we_n  = mem_we_n_o;
        prev_done  = done_o;
        prev_dq_oe = mem_dq_oe_o;
        prev_addr  = mem_addr_o;
    end

    task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          input bit chk_lat, input bit disturb);
        int lat = 0;
        wr_i = wr; addr_i = a; wdata_i = d; req_i = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                wr_i = 1'b1; addr_i = a ^ 19'h1; wdata_i = 8'h3C;
            end
        end while (!done_o);
        req_i = 1'b0;
        if (chk_lat)
            check(lat == (wr ? EXP_WP + 1 : EXP_RD + 1), "R10 done latency",
                  lat, wr ? EXP_WP + 1 : EXP_RD + 1);
        if (wr) ref_mem[int'(a)] = d;
        else check(rdata_o == ref_byte(int'(a)), wr ? "R4 write" : "R3 read data",
                   rdata_o, ref_byte(int'(a)));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n_o && mem_we_n_o && mem_oe_n_o, "R1 strobes in reset",
              {mem_cs_n_o, mem_we_n_o, mem_oe_n_o}, 7);
        check(!mem_dq_oe_o && !done_o, "R1 driver and done in reset", {mem_dq_oe_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !done_o,
              "R1 state after reset", {mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, done_o}, 5'b11100);

        // R4 / R3 patterns at edge and middle addresses
        access(1, 19'h00000, 8'h55, 1, 0); settle();
        access(1, 19'h7FFFF, 8'hAA, 1, 0); settle();
        access(1, 19'h2A5A5, 8'hFF, 1, 0); settle();
        access(1, 19'h15A5A, 8'h00, 1, 0); settle();
        access(0, 19'h00000, 8'h00, 1, 0); settle();
        access(0, 19'h7FFFF, 8'h00, 1, 0); settle();
        access(0, 19'h2A5A5, 8'h00, 1, 0); settle();
        access(0, 19'h15A5A, 8'h00, 1, 0); settle();

        // R8 back-to-back alternating directions with no idle gap
        for (int i = 0; i < 4; i++) begin
            access(1, 19'h01234, 8'(8'h11 * (i + 1)), 0, 0);
            access(0, 19'h01234, 8'h00, 0, 0);
        end
        settle();

        // R9: inputs changed mid-read are ignored
        access(1, 19'h00101, 8'h77, 1, 0); settle();
        access(0, 19'h00100, 8'h00, 1, 1); settle();
        access(0, 19'h00101, 8'h00, 1, 0); settle();
        check(ref_byte(32'h101) == 8'h77, "R9 no stray write", ref_byte(32'h101), 8'h77);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R10 actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule